// File: doc/BRIEF.md
# DMA Channel Address and Terminal-Count Engine

This block keeps the per-channel bookkeeping of one DMA channel. A processor-side register port loads a starting memory address, a count word (a two-bit transfer type above an N−1 cycle count) and a small control word. While the channel is enabled, each granted DMA cycle is accepted. The engine presents the current memory address during that cycle, then steps the address and the remaining count at the clock edge.

When the last programmed cycle is accepted, the engine raises a one-cycle terminal-count strobe and latches a terminal-count status bit. Without autoload, the channel then stops. With autoload, the working registers are refilled from a reload copy, and the next block runs immediately. The processor may rewrite the reload copy during a block to chain into a different block. A mark strobe fires after every fixed group of accepted cycles, counted from the start of each block. Bus multiplexing, address latching, strobe timing and arbitration between channels sit outside this block.

Top module: `dma_chan_engine`

## Requirements
- R1: While `rst_i` is high and after it falls, `mem_addr_o`, `dir_o`, `ready_o`, `tc_o`, `mark_o`, `stat_tc_o` and `stat_upd_o` are all zero, and control, count-loaded and flag state are cleared.
- R2: `mem_addr_o` shows the working address. Each accepted cycle (`dma_cycle_i` high while `ready_o` is high) advances it by one, wrapping modulo 2^16.
- R3: `ready_o` is high only when the channel is enabled, a count word has been loaded since the last stop, and the transfer type is not 11. A `dma_cycle_i` while `ready_o` is low changes nothing.
- R4: Count word layout: bits [15:14] give the transfer type (00 verify, 01 write, 10 read, 11 illegal), shown on `dir_o`. Bits [13:0] hold N−1 for N cycles. `tc_o` is high for the one cycle after the edge that accepts the Nth cycle.
- R5: At terminal count without autoload, the engine clears its enable and count-loaded state. `ready_o` stays low until a new count word and an enable are written.
- R6: `stat_tc_o` is set at terminal count. A `rd_stat_i` pulse clears it at the edge, unless terminal count is reached at that same edge. `rd_stat_i` does not affect `stat_upd_o`.
- R7: `mark_o` is high for one cycle after every 128th accepted cycle of a block, counted from the block's first cycle.
- R8: With autoload set, terminal count reloads the working address, count and type from the reload copy, sets `stat_upd_o`, and leaves `ready_o` high.
- R9: A register write while `ready_o` is high updates only the reload copy. While `ready_o` is low, it updates both the reload copy and the working registers.
- R10: `stat_upd_o` clears at the first accepted cycle after the reload that set it.
- R11: `wr_sel_i` selects the register written by `wr_en_i`: 00 address, 01 count word, 10 control (bit 0 enable, bit 1 autoload), 11 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 16 | Register write data |
| rd_stat_i | input | 1 | Status read strobe, clears terminal-count status |
| dma_cycle_i | input | 1 | Granted DMA cycle for this channel |
| mem_addr_o | output | 16 | Working memory address |
| dir_o | output | 2 | Working transfer type |
| ready_o | output | 1 | Channel can accept cycles |
| tc_o | output | 1 | Terminal-count strobe |
| mark_o | output | 1 | Periodic mark strobe |
| stat_tc_o | output | 1 | Latched terminal-count status |
| stat_upd_o | output | 1 | Autoload update flag |

## Verification
The assertions assume that register writes never share a cycle with an accepted DMA cycle. Under that assumption, an address change while the channel is not ready can only come from a write, and a block change can only come from terminal count. The stimulus drives writes, status reads and DMA cycles in separate clock ticks, except for deliberate read-with-cycle pairs that exercise the set-over-clear rule. No write is issued while an accepted cycle is pending.

// File: rtl/dmace_pkg.sv
package dmace_pkg;

   typedef enum logic [1:0] {
      OP_VERIFY  = 2'b00,
      OP_WRITE   = 2'b01,
      OP_READ    = 2'b10,
      OP_ILLEGAL = 2'b11
   } dma_op_e;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'b00,
      SEL_COUNT = 2'b01,
      SEL_CTRL  = 2'b10,
      SEL_NONE  = 2'b11
   } reg_sel_e;

endpackage

// File: rtl/dmace_addr_unit.sv
module dmace_addr_unit #(
   parameter int ADDR_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_base_i,
   input  logic              ld_cur_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              step_i,
   input  logic              reload_i,
   output logic [ADDR_W-1:0] cur_addr_o
);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] cur_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         base_q <= '0;
      end else if (ld_base_i) begin
         base_q <= wr_addr_i;
      end
   end

   // reload wins over step: the terminal cycle starts the next block
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cur_q <= '0;
      end else if (reload_i) begin
         cur_q <= base_q;
      end else if (step_i) begin
         cur_q <= cur_q + ADDR_ONE;
      end else if (ld_cur_i) begin
         cur_q <= wr_addr_i;
      end
   end

   assign cur_addr_o = cur_q;
endmodule

// File: rtl/dmace_count_unit.sv
module dmace_count_unit #(
   parameter int CNT_W         = 14,
   parameter int MARK_INTERVAL = 128,
   parameter bit MARK_EN       = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             ld_base_i,
   input  logic             ld_cur_i,
   input  logic [CNT_W-1:0] wr_cnt_i,
   input  logic [1:0]       wr_op_i,
   input  logic             step_i,
   input  logic             auto_i,
   output logic [1:0]       cur_op_o,
   output logic             tc_hit_o,
   output logic             reload_o,
   output logic             mark_hit_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam int               MARK_W  = (MARK_INTERVAL > 2) ? $clog2(MARK_INTERVAL) : 1;

   logic [CNT_W-1:0] base_cnt_q;
   logic [1:0]       base_op_q;
   logic [CNT_W-1:0] cur_cnt_q;
   logic [1:0]       cur_op_q;

   assign tc_hit_o = step_i && (cur_cnt_q == '0);
   assign reload_o = tc_hit_o && auto_i;
   assign cur_op_o = cur_op_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         base_cnt_q <= '0;
         base_op_q  <= '0;
      end else if (ld_base_i) begin
         base_cnt_q <= wr_cnt_i;
         base_op_q  <= wr_op_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cur_cnt_q <= '0;
         cur_op_q  <= '0;
      end else if (reload_o) begin
         cur_cnt_q <= base_cnt_q;
         cur_op_q  <= base_op_q;
      end else if (step_i) begin
         if (cur_cnt_q != '0) begin
            cur_cnt_q <= cur_cnt_q - CNT_ONE;
         end
      end else if (ld_cur_i) begin
         cur_cnt_q <= wr_cnt_i;
         cur_op_q  <= wr_op_i;
      end
   end

   generate
      if (MARK_EN) begin : g_mark
         localparam logic [MARK_W-1:0] MARK_LAST = MARK_W'(MARK_INTERVAL - 1);
         localparam logic [MARK_W-1:0] MARK_ONE  = MARK_W'(1);
         logic [MARK_W-1:0] mcnt_q;

         assign mark_hit_o = step_i && (mcnt_q == MARK_LAST);

         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               mcnt_q <= '0;
            end else if (reload_o || (ld_cur_i && !step_i)) begin
               mcnt_q <= '0;
            end else if (step_i) begin
               mcnt_q <= (mcnt_q == MARK_LAST) ? '0 : mcnt_q + MARK_ONE;
            end
         end
      end else begin : g_no_mark
         assign mark_hit_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dmace_status.sv
module dmace_status (
   input  logic clk_i,
   input  logic rst_i,
   input  logic step_i,
   input  logic tc_hit_i,
   input  logic reload_i,
   input  logic mark_hit_i,
   input  logic rd_stat_i,
   output logic tc_o,
   output logic mark_o,
   output logic stat_tc_o,
   output logic stat_upd_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         tc_o       <= 1'b0;
         mark_o     <= 1'b0;
         stat_tc_o  <= 1'b0;
         stat_upd_o <= 1'b0;
      end else begin
         tc_o   <= tc_hit_i;
         mark_o <= mark_hit_i;
         // a new terminal count outranks the clear-on-read
         if (tc_hit_i) begin
            stat_tc_o <= 1'b1;
         end else if (rd_stat_i) begin
            stat_tc_o <= 1'b0;
         end
         if (reload_i) begin
            stat_upd_o <= 1'b1;
         end else if (step_i) begin
            stat_upd_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dmace_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int CNT_W         = 14,
   parameter int DATA_W        = 16,
   parameter int MARK_INTERVAL = 128,
   parameter bit MARK_EN       = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_stat_i,
   input  logic              dma_cycle_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [1:0]        dir_o,
   output logic              ready_o,
   output logic              tc_o,
   output logic              mark_o,
   output logic              stat_tc_o,
   output logic              stat_upd_o
);
   localparam int OP_LSB = CNT_W;

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("dma_chan_engine: ADDR_W must be 1..DATA_W");
      end
      if (CNT_W < 1 || CNT_W + 2 > DATA_W) begin : g_bad_cnt_w
         $error("dma_chan_engine: CNT_W + 2 must fit in DATA_W");
      end
      if (MARK_INTERVAL < 2) begin : g_bad_mark
         $error("dma_chan_engine: MARK_INTERVAL must be at least 2");
      end
   endgenerate

   logic en_q, auto_q, loaded_q;
   logic [1:0] cur_op;
   logic accept, tc_hit, reload, mark_hit;
   logic wr_addr, wr_cnt, wr_ctrl;

   assign ready_o = en_q && loaded_q && (dma_op_e'(cur_op) != OP_ILLEGAL);
   assign accept  = dma_cycle_i && ready_o;

   assign wr_addr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ADDR);
   assign wr_cnt  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_COUNT);
   assign wr_ctrl = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         en_q     <= 1'b0;
         auto_q   <= 1'b0;
         loaded_q <= 1'b0;
      end else begin
         if (tc_hit && !auto_q) begin
            en_q     <= 1'b0;
            loaded_q <= 1'b0;
         end else begin
            if (wr_ctrl) begin
               en_q <= wr_data_i[0];
            end
            if (wr_cnt) begin
               loaded_q <= 1'b1;
            end
         end
         if (wr_ctrl) begin
            auto_q <= wr_data_i[1];
         end
      end
   end

   dmace_addr_unit #(
      .ADDR_W (ADDR_W)
   ) u_addr (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .ld_base_i  (wr_addr),
      .ld_cur_i   (wr_addr && !ready_o),
      .wr_addr_i  (wr_data_i[ADDR_W-1:0]),
      .step_i     (accept),
      .reload_i   (reload),
      .cur_addr_o (mem_addr_o)
   );

   dmace_count_unit #(
      .CNT_W         (CNT_W),
      .MARK_INTERVAL (MARK_INTERVAL),
      .MARK_EN       (MARK_EN)
   ) u_count (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .ld_base_i  (wr_cnt),
      .ld_cur_i   (wr_cnt && !ready_o),
      .wr_cnt_i   (wr_data_i[CNT_W-1:0]),
      .wr_op_i    (wr_data_i[OP_LSB+1:OP_LSB]),
      .step_i     (accept),
      .auto_i     (auto_q),
      .cur_op_o   (cur_op),
      .tc_hit_o   (tc_hit),
      .reload_o   (reload),
      .mark_hit_o (mark_hit)
   );

   dmace_status u_status (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .step_i     (accept),
      .tc_hit_i   (tc_hit),
      .reload_i   (reload),
      .mark_hit_i (mark_hit),
      .rd_stat_i  (rd_stat_i),
      .tc_o       (tc_o),
      .mark_o     (mark_o),
      .stat_tc_o  (stat_tc_o),
      .stat_upd_o (stat_upd_o)
   );

   assign dir_o = cur_op;
endmodule

// File: rtl/dmace_chk.sv
module dmace_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              wr_en_i,
   input logic              dma_cycle_i,
   input logic              rd_stat_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [1:0]        dir_o,
   input logic              ready_o,
   input logic              tc_o,
   input logic              mark_o,
   input logic              stat_tc_o,
   input logic              stat_upd_o
);
   AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (dma_cycle_i && ready_o) |=> (stat_upd_o || (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1)))); // R2

   AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ready_o && !wr_en_i) |=> $stable(mem_addr_o)); // R3

   AST_ILLEGAL_NOT_READY: assert property (@(posedge clk_i) disable iff (rst_i)
      (dir_o == 2'b11) |-> !ready_o); // R3

   AST_TC_FROM_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o |-> $past(dma_cycle_i && ready_o)); // R4

   AST_TC_LATCHED: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o |-> stat_tc_o); // R6

   AST_STATUS_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_stat_i && !(dma_cycle_i && ready_o)) |=> !stat_tc_o); // R6

   AST_MARK_FROM_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      mark_o |-> $past(dma_cycle_i && ready_o)); // R7

   AST_UPDATE_AT_TC: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(stat_upd_o) |-> (tc_o && ready_o)); // R8

   AST_UPDATE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (stat_upd_o && dma_cycle_i && ready_o) |=> (!stat_upd_o || tc_o)); // R10
endmodule

bind dma_chan_engine dmace_chk #(
   .ADDR_W (ADDR_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .wr_en_i     (wr_en_i),
   .dma_cycle_i (dma_cycle_i),
   .rd_stat_i   (rd_stat_i),
   .mem_addr_o  (mem_addr_o),
   .dir_o       (dir_o),
   .ready_o     (ready_o),
   .tc_o        (tc_o),
   .mark_o      (mark_o),
   .stat_tc_o   (stat_tc_o),
   .stat_upd_o  (stat_upd_o)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [15:0] wr_data;
   logic        rd_stat;
   logic        dma_cycle;
   logic [15:0] mem_addr;
   logic [1:0]  dir;
   logic        ready, tc, mark, stat_tc, stat_upd;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_base_addr, m_cur_addr, m_base_n, m_left, m_base_op, m_op, m_done;
   bit m_en, m_auto, m_loaded, m_tc_st, m_upd, m_tc, m_mark;

   always #2.5 clk = ~clk;   // 200 MHz

   dma_chan_engine u_dut (
      .clk_i       (clk),
      .rst_i       (rst),
      .wr_en_i     (wr_en),
      .wr_sel_i    (wr_sel),
      .wr_data_i   (wr_data),
      .rd_stat_i   (rd_stat),
      .dma_cycle_i (dma_cycle),
      .mem_addr_o  (mem_addr),
      .dir_o       (dir),
      .ready_o     (ready),
      .tc_o        (tc),
      .mark_o      (mark),
      .stat_tc_o   (stat_tc),
      .stat_upd_o  (stat_upd)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit m_ready();
      return m_en && m_loaded && (m_op != 3);
   endfunction

   task automatic model_reset();
      m_base_addr = 0; m_cur_addr = 0; m_base_n = 0; m_left = 0;
      m_base_op = 0; m_op = 0; m_done = 0;
      m_en = 0; m_auto = 0; m_loaded = 0; m_tc_st = 0; m_upd = 0; m_tc = 0; m_mark = 0;
   endtask

   task automatic model_step(input bit w, input int sel, input int data, input bit cyc, input bit rd);
      bit rdy = m_ready();
      bit acc = cyc && rdy;
      bit hit = 0;
      m_tc = 0;
      m_mark = 0;
      if (acc) begin
         m_cur_addr = (m_cur_addr + 1) % 65536;
         m_done++;
         m_left--;
         m_upd = 0;
         if (m_done % 128 == 0) m_mark = 1;
         if (m_left == 0) begin
            hit = 1;
            m_tc = 1;
            if (m_auto) begin
               m_cur_addr = m_base_addr; m_left = m_base_n; m_op = m_base_op;
               m_done = 0; m_upd = 1;
            end else begin
               m_en = 0; m_loaded = 0;
            end
         end
      end
      if (rd) m_tc_st = 0;
      if (hit) m_tc_st = 1;
      if (w) begin
         case (sel)
            0: begin
               m_base_addr = data;
               if (!rdy) m_cur_addr = data;
            end
            1: begin
               m_base_n = (data % 16384) + 1;
               m_base_op = data / 16384;
               if (!rdy) begin m_left = m_base_n; m_op = m_base_op; m_done = 0; end
               if (!(hit && !m_auto)) m_loaded = 1;
            end
            2: begin
               if (!(hit && !m_auto)) m_en = data[0];
               m_auto = data[1];
            end
            default: ;
         endcase
      end
   endtask

   task automatic compare_all();
      check("R2", "mem_addr", int'(mem_addr), m_cur_addr);
      check("R3", "ready", int'(ready), int'(m_ready()));
      check("R4", "dir", int'(dir), m_op);
      check("R4", "tc", int'(tc), int'(m_tc));
      check("R7", "mark", int'(mark), int'(m_mark));
      check("R6", "stat_tc", int'(stat_tc), int'(m_tc_st));
      check("R10", "stat_upd", int'(stat_upd), int'(m_upd));
   endtask

   task automatic tick(input bit w, input int sel, input int data, input bit cyc, input bit rd);
      wr_en = w; wr_sel = 2'(sel); wr_data = 16'(data); dma_cycle = cyc; rd_stat = rd;
      @(posedge clk);
      #1;
      model_step(w, sel, data, cyc, rd);
      @(negedge clk);
      wr_en = 0; dma_cycle = 0; rd_stat = 0;
      compare_all();
   endtask

   task automatic wr_reg(input int sel, input int data);
      tick(1, sel, data, 0, 0);
   endtask

   task automatic cycle();
      tick(0, 3, 0, 1, 0);
   endtask

   task automatic do_reset();
      rst = 1;
      wr_en = 0; wr_sel = 0; wr_data = 0; dma_cycle = 0; rd_stat = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      model_reset();
      check("R1", "reset addr", int'(mem_addr), 0);
      check("R1", "reset ready", int'(ready), 0);
      check("R1", "reset dir", int'(dir), 0);
      check("R1", "reset strobes", int'({tc, mark}), 0);
      check("R1", "reset status", int'({stat_tc, stat_upd}), 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();

      // R3: enabled without a count: no effect
      wr_reg(2, 1);
      repeat (3) cycle();
      check("R3", "unloaded ready", int'(ready), 0);
      check("R3", "unloaded addr", int'(mem_addr), 0);

      // R11: address write while not ready reaches working register
      wr_reg(0, 16'h1000);
      check("R11", "addr write", int'(mem_addr), 16'h1000);
      wr_reg(3, 16'h5555);
      check("R11", "select 11 writes nothing", int'(mem_addr), 16'h1000);
      // R4: write type, 5 cycles
      wr_reg(1, 16'h4004);
      check("R4", "dir write", int'(dir), 1);
      for (int i = 0; i < 5; i++) begin
         cycle();
         if (i % 2 == 0) tick(0, 3, 0, 0, 0);
      end
      // R5: stopped, re-enable alone is not enough
      check("R5", "stopped", int'(ready), 0);
      wr_reg(2, 1);
      cycle();
      check("R5", "re-enable without count", int'(ready), 0);
      tick(0, 3, 0, 0, 1);
      check("R6", "status cleared by read", int'(stat_tc), 0);

      // R3: illegal type never runs
      wr_reg(1, 16'hC003);
      repeat (2) cycle();
      check("R3", "illegal type", int'(ready), 0);
      // R4: single-cycle block, count field 0
      wr_reg(1, 16'h4000);
      cycle();
      check("R4", "one-cycle block tc", int'(tc), 1);

      // R7 / R2: 300-cycle read block across the address wrap
      wr_reg(0, 16'hFFF0);
      wr_reg(1, 16'h8000 + 299);
      wr_reg(2, 1);
      for (int i = 0; i < 300; i++) begin
         cycle();
         if (i % 7 == 3) tick(0, 3, 0, 0, 0);
      end
      check("R2", "wrapped end address", int'(mem_addr), (16'hFFF0 + 300) % 65536);
      tick(0, 3, 0, 0, 1);

      // R8 / R9 / R10: autoload with chaining
      wr_reg(0, 16'h2000);
      wr_reg(1, 16'h4002);
      wr_reg(2, 3);
      cycle();
      wr_reg(0, 16'h3000);
      check("R9", "base-only addr write", int'(mem_addr), 16'h2001);
      wr_reg(1, 16'h0001);
      check("R9", "base-only count write", int'(dir), 1);
      repeat (2) cycle();
      check("R8", "reloaded address", int'(mem_addr), 16'h3000);
      check("R8", "update flag", int'(stat_upd), 1);
      check("R8", "still ready", int'(ready), 1);
      tick(0, 3, 0, 0, 1);
      check("R6", "read keeps update", int'(stat_upd), 1);
      cycle();
      check("R10", "update cleared", int'(stat_upd), 0);
      cycle();
      tick(0, 3, 0, 1, 1);
      tick(0, 3, 0, 1, 1);
      check("R6", "set beats read", int'(stat_tc), 1);
      wr_reg(2, 0);
      repeat (2) cycle();

      // R1: reset in the middle of a block
      wr_reg(1, 16'h4010);
      wr_reg(2, 1);
      repeat (3) cycle();
      do_reset();

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule